// File: doc/BRIEF.md
# Line-Parity Load/Store Splitter

This block sits between a load/store unit and a pair of cache-line ports. It takes one access, given as a byte address, a byte count from 1 to 16 and up to `DATA_W/8` bytes of store data. It turns that access into work on two outgoing ports. Each port covers one 16-byte line and carries 128 data bits and a 16-bit byte enable. Lines whose address bit 4 is clear always go to port 0. Lines whose bit 4 is set always go to port 1. An access that runs past the end of its line therefore uses both ports: its own line goes to the port of matching parity, and the following line goes to the other port.

The incoming side follows a request/acknowledge handshake:

1. A one-cycle load or store request raises busy.
2. The address and its valid flag are held until busy falls.
3. The splitter returns one address acknowledge, or an exception.
4. A store is then completed with a one-cycle store-valid strobe.
5. A load is completed by a one-cycle load-valid that carries the recombined, length-masked result.

The outgoing ports use the same style of handshake, seen from the other side.

Top module: `ldst_line_splitter`

## Requirements
- R1: While reset is held, busy, every outgoing request, the address acknowledge, the exception and load-valid are all low.
- R2: A load or store request seen while idle raises busy on the next cycle. Busy stays high until the access completes or raises an exception. When both request inputs are high, the access is a store.
- R3: The outgoing byte enables form a 32-bit span, `((1 << len) - 1) << addr[3:0]`. Span bits 15..0 go to the port numbered `addr[4]`, and span bits 31..16 go to the other port. A length code of 16 gives a full 16-bit run. While busy and the incoming address is valid, a port raises its request exactly when its enable field is nonzero.
- R4: The port numbered `addr[4]` gets the line-aligned address `{addr[ADDR_W-1:4], 4'b0}`. The other port gets that value plus 16. Every requested port address therefore has bit 4 equal to its port number.
- R5: The incoming address acknowledge is a single-cycle pulse. It is raised in the same cycle as the acknowledge from the last requesting port.
- R6: An address exception from any requesting port raises the incoming exception in the same cycle, with no address acknowledge. Busy is low from the next cycle.
- R7: Store byte `i` lands in lane `addr[3:0] + i` of the 32-byte span. Lanes 0..15 go to the port numbered `addr[4]`, and lanes 16..31 go to the other port. Lanes past the supplied store data carry zero.
- R8: The incoming store-valid is forwarded in the same cycle to every requesting port and to no other port. Busy is low from the next cycle.
- R9: Load-valid is raised in the same cycle as the load data of the last requesting port. The result byte `i` is the memory byte at `addr + i` for `i < len`, and zero for bytes at or beyond `len`. Busy is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ld_i | input | 1 | One-cycle load request |
| in_st_i | input | 1 | One-cycle store request |
| in_addr_i | input | ADDR_W | Byte address, held until busy falls |
| in_addr_ok_i | input | 1 | Address valid, held until busy falls |
| in_len_i | input | 5 | Byte count, 1 to 16 |
| in_st_data_i | input | DATA_W | Store data, byte 0 in bits 7..0 |
| in_st_ok_i | input | 1 | One-cycle store-valid after the acknowledge |
| in_busy_o | output | 1 | Access in progress |
| in_addr_ack_o | output | 1 | One-cycle address acknowledge |
| in_addr_exc_o | output | 1 | One-cycle address exception |
| in_ld_data_o | output | DATA_W | Recombined load result |
| in_ld_ok_o | output | 1 | One-cycle load-valid |
| out_req_o | output | 2 | Per-port request |
| out_is_st_o | output | 2 | Per-port request is a store |
| out_addr_o | output | 2 x ADDR_W | Per-port line address |
| out_be_o | output | 2 x 16 | Per-port byte enables |
| out_addr_ok_i | input | 2 | Per-port address acknowledge |
| out_addr_exc_i | input | 2 | Per-port address exception |
| out_ld_ok_i | input | 2 | Per-port load-valid |
| out_ld_data_i | input | 2 x 128 | Per-port line data |
| out_st_ok_o | output | 2 | Per-port store-valid |
| out_st_data_o | output | 2 x 128 | Per-port line store data |

## Verification
The bench targets accesses that start on an odd line and spill into the next even line. A splitter that picked ports by position rather than parity would send the spill to the wrong port or the wrong address. It also covers 3-byte and 16-byte lengths, where a faulty run or shift would enable the wrong lanes or return stale bytes above the length. The two ports answer with unequal latencies in both orders, so an acknowledge or load-valid raised on the first answer, instead of the last, shows up as an early cycle count or a wrong half in the result. A store/load round trip through a model memory exposes any misrouted byte lane. An exception on one half checks that no acknowledge leaks and that busy drops.

// File: rtl/ldst_line_splitter.sv
module ldst_line_splitter #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int LINE_B = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_ld_i,
  input  logic                           in_st_i,
  input  logic [ADDR_W-1:0]              in_addr_i,
  input  logic                           in_addr_ok_i,
  input  logic [$clog2(LINE_B):0]        in_len_i,
  input  logic [DATA_W-1:0]              in_st_data_i,
  input  logic                           in_st_ok_i,
  output logic                           in_busy_o,
  output logic                           in_addr_ack_o,
  output logic                           in_addr_exc_o,
  output logic [DATA_W-1:0]              in_ld_data_o,
  output logic                           in_ld_ok_o,
  output logic [1:0]                     out_req_o,
  output logic [1:0]                     out_is_st_o,
  output logic [1:0][ADDR_W-1:0]         out_addr_o,
  output logic [1:0][LINE_B-1:0]         out_be_o,
  input  logic [1:0]                     out_addr_ok_i,
  input  logic [1:0]                     out_addr_exc_i,
  input  logic [1:0]                     out_ld_ok_i,
  input  logic [1:0][LINE_B*8-1:0]       out_ld_data_i,
  output logic [1:0]                     out_st_ok_o,
  output logic [1:0][LINE_B*8-1:0]       out_st_data_o
);
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int LW     = LINE_B * 8;
  localparam int SPAN_B = 2 * LINE_B;
  localparam int DB     = DATA_W / 8;

  logic busy_q, st_q, ack_sent_q;
  logic [1:0] acked_q, got_q;
  logic [1:0][LW-1:0] hold_q;

  wire [OFF_W-1:0]  off = in_addr_i[OFF_W-1:0];
  wire              par = in_addr_i[OFF_W];
  wire [ADDR_W-1:0] line_base = {in_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  wire [ADDR_W-1:0] next_base = line_base + ADDR_W'(LINE_B);

  logic [SPAN_B-1:0] run_w, span_be;
  assign run_w   = ({{(SPAN_B-1){1'b0}}, 1'b1} << in_len_i) - 1'b1;
  assign span_be = {{LINE_B{1'b0}}, run_w[LINE_B-1:0]} << off;

  logic [2*LW-1:0] st_span, ld_span;
  assign st_span = {{(2*LW-DATA_W){1'b0}}, in_st_data_i} << {off, 3'b000};

  logic [1:0] have_be, ack_now, ld_now;
  logic [1:0][LW-1:0] line_val;

  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_port
      wire first = (par == 1'(p));
      assign out_be_o[p]      = first ? span_be[LINE_B-1:0] : span_be[SPAN_B-1:LINE_B];
      assign out_addr_o[p]    = first ? line_base : next_base;
      assign out_st_data_o[p] = first ? st_span[LW-1:0] : st_span[2*LW-1:LW];
      assign have_be[p]       = |out_be_o[p];
      assign out_req_o[p]     = busy_q & in_addr_ok_i & have_be[p];
      assign out_is_st_o[p]   = out_req_o[p] & st_q;
      assign out_st_ok_o[p]   = out_is_st_o[p] & in_st_ok_i;
      assign ack_now[p]       = out_req_o[p] & out_addr_ok_i[p];
      assign ld_now[p]        = out_req_o[p] & ~st_q & out_ld_ok_i[p];
      assign line_val[p]      = out_ld_ok_i[p] ? out_ld_data_i[p] : hold_q[p];

      p_port_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_req_o[p] |-> (out_addr_o[p][OFF_W] == 1'(p)));
      p_st_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_st_ok_o[p] |-> (in_st_ok_i && in_busy_o));
    end
  endgenerate

  assign ld_span = (par ? {line_val[0], line_val[1]} : {line_val[1], line_val[0]}) >> {off, 3'b000};

  genvar b;
  generate
    for (b = 0; b < DB; b++) begin : g_keep
      assign in_ld_data_o[8*b +: 8] = run_w[b] ? ld_span[8*b +: 8] : 8'h00;
    end
  endgenerate

  wire exc_hit  = busy_q & |(out_addr_exc_i & out_req_o);
  wire all_ack  = (((acked_q | ack_now) & have_be) == have_be);
  wire all_ld   = (((got_q | ld_now) & have_be) == have_be);
  wire st_done  = busy_q & st_q & in_st_ok_i;

  assign in_busy_o     = busy_q;
  assign in_addr_exc_o = exc_hit;
  assign in_addr_ack_o = busy_q & in_addr_ok_i & ~ack_sent_q & all_ack & ~exc_hit;
  assign in_ld_ok_o    = busy_q & ~st_q & ack_sent_q & all_ld & (|ld_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      st_q       <= 1'b0;
      ack_sent_q <= 1'b0;
      acked_q    <= '0;
      got_q      <= '0;
      hold_q     <= '0;
    end else if (!busy_q) begin
      if (in_ld_i | in_st_i) begin
        busy_q <= 1'b1;
        st_q   <= in_st_i;
      end
      ack_sent_q <= 1'b0;
      acked_q    <= '0;
      got_q      <= '0;
    end else begin
      if (exc_hit | in_ld_ok_o | st_done) busy_q <= 1'b0;
      if (in_addr_ack_o) ack_sent_q <= 1'b1;
      acked_q <= acked_q | ack_now;
      got_q   <= got_q | ld_now;
      for (int i = 0; i < 2; i++)
        if (ld_now[i]) hold_q[i] <= out_ld_data_i[i];
    end
  end

  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr_ack_o |=> !in_addr_ack_o);
  p_exc_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr_exc_o |=> !in_busy_o);
  p_ld_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ld_ok_o |=> !in_busy_o);
  p_st_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_st_ok_o) |=> !in_busy_o);
  p_no_ack_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr_exc_o |-> !in_addr_ack_o);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_busy_o && (in_ld_i || in_st_i)) |=> in_busy_o);
endmodule

// File: tb/test_ldst_line_splitter.sv
`timescale 1ns/1ps
module test_ldst_line_splitter;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic in_ld_i = 0, in_st_i = 0, in_addr_ok_i = 0, in_st_ok_i = 0;
  logic [47:0] in_addr_i = '0;
  logic [4:0]  in_len_i = '0;
  logic [63:0] in_st_data_i = '0;
  logic in_busy_o, in_addr_ack_o, in_addr_exc_o, in_ld_ok_o;
  logic [63:0] in_ld_data_o;
  logic [1:0] out_req_o, out_is_st_o, out_st_ok_o;
  logic [1:0][47:0] out_addr_o;
  logic [1:0][15:0] out_be_o;
  logic [1:0] out_addr_ok_i = 0, out_addr_exc_i = 0, out_ld_ok_i = 0;
  logic [1:0][127:0] out_ld_data_i = '0;
  logic [1:0][127:0] out_st_data_o;

  ldst_line_splitter i_ldst_line_splitter (
    .clk, .rst_n, .in_ld_i, .in_st_i, .in_addr_i, .in_addr_ok_i, .in_len_i,
    .in_st_data_i, .in_st_ok_i, .in_busy_o, .in_addr_ack_o, .in_addr_exc_o,
    .in_ld_data_o, .in_ld_ok_o, .out_req_o, .out_is_st_o, .out_addr_o, .out_be_o,
    .out_addr_ok_i, .out_addr_exc_i, .out_ld_ok_i, .out_ld_data_i, .out_st_ok_o,
    .out_st_data_o);

  int checks = 0, errs = 0;
  logic [7:0] mem [256];
  logic [7:0] refm [256];
  logic [63:0] exp_q [$];
  int alat [2], llat [2], cnt [2];
  bit acked [2], ldone [2];
  logic [1:0] exc_en = 0;

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // port responder: answers both outgoing ports from a byte memory
  initial begin
    logic [1:0] nx_ok, nx_exc, nx_ld;
    logic [1:0][127:0] nx_data;
    forever begin
      @(negedge clk);
      nx_ok = 0; nx_exc = 0; nx_ld = 0; nx_data = out_ld_data_i;
      for (int p = 0; p < 2; p++) begin
        if (out_st_ok_o[p])
          for (int b = 0; b < 16; b++)
            if (out_be_o[p][b]) mem[(int'(out_addr_o[p][7:0]) + b) & 255] = out_st_data_o[p][8*b +: 8];
        if (!out_req_o[p]) begin
          acked[p] = 0; ldone[p] = 0; cnt[p] = alat[p];
        end else if (!acked[p]) begin
          if (cnt[p] == 0) begin
            if (exc_en[p]) nx_exc[p] = 1; else nx_ok[p] = 1;
            acked[p] = 1; cnt[p] = llat[p];
          end else cnt[p]--;
        end else if (!out_is_st_o[p] && !ldone[p]) begin
          if (cnt[p] == 0) begin
            nx_ld[p] = 1; ldone[p] = 1;
            for (int b = 0; b < 16; b++)
              nx_data[p][8*b +: 8] = mem[(int'(out_addr_o[p][7:0]) + b) & 255];
          end else cnt[p]--;
        end
      end
      @(posedge clk); #1;
      out_addr_ok_i = nx_ok; out_addr_exc_i = nx_exc; out_ld_ok_i = nx_ld; out_ld_data_i = nx_data;
    end
  end

  // monitor: scoreboard for load results
  initial forever begin
    @(negedge clk);
    if (rst_n && in_ld_ok_o) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected load-valid", 128'(in_ld_data_o), 0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(in_ld_data_o == e, "R9 load data", 128'(in_ld_data_o), 128'(e));
      end
    end
  end

  task automatic run_op(bit st, logic [47:0] a, int len, logic [63:0] d,
                        int a0, int a1, int l0, int l1, logic [1:0] ex);
    logic [31:0] m;
    logic [1:0][15:0] ebe;
    logic [1:0][47:0] ead;
    logic [1:0] need;
    logic [63:0] eld;
    int par, cyc, exp_ack, exp_ld;
    bit got_exc;
    par = int'(a[4]);
    m = ((32'h1 << len) - 1) << a[3:0];
    ebe[par] = m[15:0]; ebe[1-par] = m[31:16];
    ead[par] = {a[47:4], 4'h0}; ead[1-par] = {a[47:4], 4'h0} + 48'd16;
    need = {|ebe[1], |ebe[0]};
    alat[0] = a0; alat[1] = a1; llat[0] = l0; llat[1] = l1;
    exp_ack = 0; exp_ld = 0;
    for (int p = 0; p < 2; p++) if (need[p]) begin
      if (1 + alat[p] > exp_ack) exp_ack = 1 + alat[p];
      if (2 + alat[p] + llat[p] > exp_ld) exp_ld = 2 + alat[p] + llat[p];
    end
    eld = 0;
    for (int i = 0; i < 8; i++) if (i < len) eld[8*i +: 8] = refm[(int'(a[7:0]) + i) & 255];

    @(posedge clk); #1;
    exc_en = ex;
    in_ld_i = !st; in_st_i = st; in_addr_i = a; in_len_i = 5'(len);
    in_addr_ok_i = 1; in_st_data_i = d;
    if (!st && (ex & need) == 0) exp_q.push_back(eld);
    @(posedge clk); #1;
    in_ld_i = 0; in_st_i = 0;
    @(negedge clk);
    chk(in_busy_o == 1, "R2 busy after request", 128'(in_busy_o), 1);
    chk(out_req_o == need, "R3 port requests", 128'(out_req_o), 128'(need));
    for (int p = 0; p < 2; p++) if (need[p]) begin
      chk(out_be_o[p] == ebe[p], "R3 byte enables", 128'(out_be_o[p]), 128'(ebe[p]));
      chk(out_addr_o[p] == ead[p], "R4 line address", 128'(out_addr_o[p]), 128'(ead[p]));
    end
    cyc = 0; got_exc = 0;
    while (cyc < 60) begin
      @(negedge clk); cyc++;
      if (in_addr_exc_o) begin got_exc = 1; break; end
      if (in_addr_ack_o) break;
    end
    if ((ex & need) != 0) begin
      chk(got_exc, "R6 exception raised", 128'(got_exc), 1);
      chk(in_addr_ack_o == 0, "R6 no acknowledge with exception", 128'(in_addr_ack_o), 0);
      @(negedge clk);
      chk(in_busy_o == 0, "R6 busy falls after exception", 128'(in_busy_o), 0);
    end else begin
      chk(!got_exc && cyc == exp_ack, "R5 acknowledge cycle", 128'(cyc), 128'(exp_ack));
      if (st) begin
        @(posedge clk); #1; in_st_ok_i = 1;
        @(negedge clk);
        chk(out_st_ok_o == need, "R8 store-valid fan-out", 128'(out_st_ok_o), 128'(need));
        @(posedge clk); #1; in_st_ok_i = 0;
        @(negedge clk);
        chk(in_busy_o == 0, "R8 busy falls after store", 128'(in_busy_o), 0);
        for (int i = 0; i < len; i++)
          refm[(int'(a[7:0]) + i) & 255] = (i < 8) ? d[8*i +: 8] : 8'h00;
      end else begin
        while (!in_ld_ok_o && cyc < 60) begin @(negedge clk); cyc++; end
        chk(cyc == exp_ld, "R9 load-valid cycle", 128'(cyc), 128'(exp_ld));
        @(negedge clk);
        chk(in_busy_o == 0, "R9 busy falls after load", 128'(in_busy_o), 0);
      end
    end
    @(posedge clk); #1; in_addr_ok_i = 0;
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); refm[i] = 8'(i * 7 + 3); end
    alat[0] = 0; alat[1] = 0; llat[0] = 0; llat[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_busy_o == 0 && out_req_o == 0, "R1 reset busy/requests", 128'({in_busy_o, out_req_o}), 0);
    chk(in_addr_ack_o == 0 && in_addr_exc_o == 0 && in_ld_ok_o == 0, "R1 reset strobes",
        128'({in_addr_ack_o, in_addr_exc_o, in_ld_ok_o}), 0);
    @(posedge clk); #1; rst_n = 1;

    run_op(1, 48'h20, 8, 64'h1122334455667788, 0, 0, 0, 0, 2'b00);  // R3 single even line
    run_op(1, 48'h3A, 8, 64'hA1B2C3D4E5F60718, 2, 0, 0, 0, 2'b00);  // R7 odd line spilling to even
    run_op(0, 48'h3A, 8, 0, 0, 3, 1, 0, 2'b00);                    // R9 recombine, port1 last
    run_op(0, 48'h20, 8, 0, 1, 0, 2, 0, 2'b00);
    run_op(0, 48'h2E, 3, 0, 4, 0, 0, 2, 2'b00);                    // R9 short length, crossing
    run_op(1, 48'h55, 16, 64'h0F1E2D3C4B5A6978, 1, 1, 0, 0, 2'b00); // R3 length 16
    run_op(0, 48'h55, 16, 0, 0, 0, 3, 0, 2'b00);
    run_op(0, 48'h5C, 8, 0, 2, 1, 0, 1, 2'b00);
    run_op(0, 48'h3C, 8, 0, 0, 2, 0, 0, 2'b10);                    // R6 exception on port 1
    run_op(1, 48'h1F, 2, 64'hBEEF, 0, 0, 0, 0, 2'b00);              // R7 two-byte crossing
    run_op(0, 48'h1E, 4, 0, 0, 0, 0, 0, 2'b00);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all loads completed", 128'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule